// File: doc/BRIEF.md
# Speculative Load Address Table

This block lets loads run ahead of older stores whose target addresses are not yet known, and catches the cases where such a load read stale data. Each speculative load takes one table slot holding its word address, its age tag and any fault it raised. When an older store later commits, its address and tag are compared with every live slot in the same cycle. Any younger load to the same word is squashed, and the pipeline must re-execute it.

The block also answers a retire query. A tracked load is safe to retire once no store older than it is still outstanding. Retiring a safe slot frees it, and the fault recorded at issue is only reported then. Every load presented, speculative or not, is also checked against the committed stores still waiting in the write-back queue, and against a store committing in the same cycle. A hit there is flagged as a read-after-write hazard. A flush empties the whole table at once.

Top module: `spec_load_table`

## Requirements
- R1: When `ld_valid` and `ld_spec` are high, the table is not full, `flush` is low and `ld_raw` is low, `ld_grant` is 1 and a free slot is filled at the next edge with the load's address, tag and fault bit.
- R2: When `st_valid` is high and a live slot holds the same word address as `st_addr` with a tag younger than `st_tag`, that slot's bit in `sq_vec` is 1 in the same cycle, and the slot is free after the next edge.
- R3: Age is decided modulo 2^TAG_W: tag a is older than tag b when bit TAG_W-1 of (a - b) is 1. A slot whose tag is equal to or older than the store's tag is never squashed by it.
- R4: When every slot is live, a load with `ld_valid` and `ld_spec` high gets `ld_stall` = 1 and `ld_grant` = 0. `ld_stall` is 0 whenever the table has a free slot.
- R5: `ld_raw` is 1 when `ld_valid` is high and `ld_addr` matches, by word, either any slot of the write-back queue with its `wbq_vld` bit set or a committing store older than `ld_tag`. A speculative load flagged this way is not given a slot.
- R6: `rt_safe` is 1 when slot `rt_idx` is live, `flush` is low, and either `pend_any` is 0 or the slot's tag is older than `pend_tag`. When `rt_commit` is high with `rt_safe`, the slot is freed and `rt_fault` shows the fault bit recorded at issue. `rt_fault` is 0 in every other cycle.
- R7: Address matches compare `addr[ADDR_W-1:2]` only, so byte addresses within one aligned 4-byte word are treated as a match.
- R8: The slot given to a load is the lowest-numbered free slot, reported on `ld_idx`.
- R9: With `flush` high, every slot is free after the edge. In that cycle `ld_grant`, `sq_vec` and `rt_safe` are all 0, whatever else is presented.
- R10: When several slots match one committing store, all of them are squashed in that cycle. `sq_tags` field i (bits i*TAG_W upward) carries slot i's tag when `sq_vec[i]` is 1, and is 0 otherwise.
- R11: An `rt_commit` on a slot that is not safe has no effect, and the slot stays live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every slot |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_spec | input | 1 | The load has older uncommitted stores and needs a slot |
| ld_addr | input | 32 | Effective byte address of the load |
| ld_tag | input | 6 | Age tag of the load |
| ld_fault | input | 1 | The load raised a fault at execution |
| ld_grant | output | 1 | A slot is allocated this cycle |
| ld_idx | output | 3 | Index of the allocated slot |
| ld_stall | output | 1 | The speculative load is refused because the table is full |
| ld_raw | output | 1 | Read-after-write hazard on a committed store |
| wbq_vld | input | 4 | Valid bits of the write-back queue slots |
| wbq_addr | input | 128 | Write-back queue addresses, slot k in bits k*32 upward |
| st_valid | input | 1 | A store commits this cycle |
| st_addr | input | 32 | Target address of the committing store |
| st_tag | input | 6 | Age tag of the committing store |
| sq_vec | output | 8 | Slots squashed this cycle |
| sq_tags | output | 48 | Tags of squashed slots, slot i in bits i*6 upward |
| pend_any | input | 1 | Some store is still uncommitted |
| pend_tag | input | 6 | Tag of the oldest uncommitted store |
| rt_idx | input | 3 | Slot being queried for retirement |
| rt_commit | input | 1 | Retire the queried slot if it is safe |
| rt_safe | output | 1 | The queried slot may retire |
| rt_fault | output | 1 | Deferred fault of the slot retiring now |

## Verification
The cycle that matters most is one where a speculative load is allocated and an older store to the same word commits. The store cannot squash a slot that does not exist yet, so the new load must be flagged on `ld_raw` and refused a slot. The bench drives exactly that pair in one cycle, and then the same pair with the store's tag younger than the load's. Its reference model predicts grant, hazard and squash for both cases, and checks that the second load is granted. A flush is also driven together with an allocation, a matching store and a retire, and every one of them must be suppressed.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int SLT_ADDR_W = 32;
  localparam int SLT_TAG_W  = 6;
  localparam int SLT_WORD_LSB = 2;

  typedef logic [SLT_ADDR_W-1:0] addr_t;
  typedef logic [SLT_TAG_W-1:0]  tag_t;

  // same aligned word: byte offset bits are ignored
  function automatic logic word_match(input addr_t a, input addr_t b);
    return a[SLT_ADDR_W-1:SLT_WORD_LSB] == b[SLT_ADDR_W-1:SLT_WORD_LSB];
  endfunction

  // a is older than b in modular tag order
  function automatic logic tag_older(input tag_t a, input tag_t b);
    tag_t diff;
    diff = a - b;
    return diff[SLT_TAG_W-1];
  endfunction
endpackage

// File: rtl/slt_alloc.sv
module slt_alloc #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DEPTH-1:0]         valid_vec,
  output logic                     full,
  output logic                     found,
  output logic [$clog2(DEPTH)-1:0] free_idx
);
  localparam int IDX_W = $clog2(DEPTH);

  always_comb begin
    found    = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        found    = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign full = &valid_vec;

  AST_ALLOC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((valid_vec | ~((DEPTH'(1) << free_idx) - DEPTH'(1))) == {DEPTH{1'b1}})); // R8
  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> !valid_vec[free_idx]); // R8
endmodule

// File: rtl/slt_entry.sv
module slt_entry
  import slt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  set,
  input  addr_t set_addr,
  input  tag_t  set_tag,
  input  logic  set_fault,
  input  logic  clr,
  input  logic  st_valid,
  input  addr_t st_addr,
  input  tag_t  st_tag,
  output logic  valid,
  output tag_t  tag,
  output logic  fault,
  output logic  hit
);
  addr_t addr;

  // a younger load to the committing store's word read stale data
  assign hit = valid && st_valid && word_match(addr, st_addr) && tag_older(st_tag, tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      tag   <= '0;
      fault <= 1'b0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (hit || clr) begin
      valid <= 1'b0;
    end else if (set) begin
      valid <= 1'b1;
      addr  <= set_addr;
      tag   <= set_tag;
      fault <= set_fault;
    end
  end

  AST_SET_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    set |-> !valid); // R1
  AST_SET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !flush) |=> (valid && tag == $past(set_tag) && fault == $past(set_fault))); // R1
endmodule

// File: rtl/slt_raw_check.sv
module slt_raw_check
  import slt_pkg::*;
#(
  parameter int WBQ_DEPTH = 4
) (
  input  logic [WBQ_DEPTH-1:0]            wbq_vld,
  input  logic [WBQ_DEPTH*SLT_ADDR_W-1:0] wbq_addr,
  input  addr_t                           ld_addr,
  output logic                            hit
);
  logic [WBQ_DEPTH-1:0] slot_hit;

  for (genvar k = 0; k < WBQ_DEPTH; k++) begin : g_slot
    assign slot_hit[k] = wbq_vld[k] &&
                         word_match(wbq_addr[k*SLT_ADDR_W +: SLT_ADDR_W], ld_addr);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import slt_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WBQ_DEPTH = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            ld_valid,
  input  logic                            ld_spec,
  input  logic [SLT_ADDR_W-1:0]           ld_addr,
  input  logic [SLT_TAG_W-1:0]            ld_tag,
  input  logic                            ld_fault,
  output logic                            ld_grant,
  output logic [$clog2(DEPTH)-1:0]        ld_idx,
  output logic                            ld_stall,
  output logic                            ld_raw,
  input  logic [WBQ_DEPTH-1:0]            wbq_vld,
  input  logic [WBQ_DEPTH*SLT_ADDR_W-1:0] wbq_addr,
  input  logic                            st_valid,
  input  logic [SLT_ADDR_W-1:0]           st_addr,
  input  logic [SLT_TAG_W-1:0]            st_tag,
  output logic [DEPTH-1:0]                sq_vec,
  output logic [DEPTH*SLT_TAG_W-1:0]      sq_tags,
  input  logic                            pend_any,
  input  logic [SLT_TAG_W-1:0]            pend_tag,
  input  logic [$clog2(DEPTH)-1:0]        rt_idx,
  input  logic                            rt_commit,
  output logic                            rt_safe,
  output logic                            rt_fault
);
  localparam int IDX_W = $clog2(DEPTH);

  // named internal events
  logic [DEPTH-1:0] ent_valid;
  logic [DEPTH-1:0] ent_fault;
  logic [DEPTH-1:0] ent_hit;
  logic [DEPTH-1:0] set_vec;
  logic [DEPTH-1:0] clr_vec;
  tag_t             ent_tag [DEPTH];
  logic             tbl_full;
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic             wbq_hit;
  logic             st_conflict;
  logic             rt_in_range;
  logic             rt_live;
  logic             rt_older_all;
  logic             retire_now;

  slt_alloc #(.DEPTH(DEPTH)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (ent_valid),
    .full      (tbl_full),
    .found     (free_found),
    .free_idx  (free_idx)
  );

  slt_raw_check #(.WBQ_DEPTH(WBQ_DEPTH)) u_raw (
    .wbq_vld  (wbq_vld),
    .wbq_addr (wbq_addr),
    .ld_addr  (ld_addr),
    .hit      (wbq_hit)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    slt_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .set       (set_vec[i]),
      .set_addr  (ld_addr),
      .set_tag   (ld_tag),
      .set_fault (ld_fault),
      .clr       (clr_vec[i]),
      .st_valid  (st_valid),
      .st_addr   (st_addr),
      .st_tag    (st_tag),
      .valid     (ent_valid[i]),
      .tag       (ent_tag[i]),
      .fault     (ent_fault[i]),
      .hit       (ent_hit[i])
    );
    assign sq_vec[i] = ent_hit[i] && !flush;
    assign sq_tags[i*SLT_TAG_W +: SLT_TAG_W] = sq_vec[i] ? ent_tag[i] : '0;
    assign set_vec[i] = ld_grant && (free_idx == IDX_W'(i));
    assign clr_vec[i] = retire_now && (rt_idx == IDX_W'(i));

    AST_SQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      sq_vec[i] |=> !ent_valid[i]); // R2
  end

  // a store committing now is not yet in the write-back queue
  assign st_conflict = st_valid && word_match(ld_addr, st_addr) && tag_older(st_tag, ld_tag);
  assign ld_raw      = ld_valid && (wbq_hit || st_conflict);

  assign ld_grant = ld_valid && ld_spec && free_found && !flush && !ld_raw;
  assign ld_stall = ld_valid && ld_spec && tbl_full && !flush;
  assign ld_idx   = free_idx;

  assign rt_in_range  = 32'(rt_idx) < DEPTH;
  assign rt_live      = rt_in_range && ent_valid[rt_idx];
  assign rt_older_all = !pend_any || tag_older(ent_tag[rt_idx], pend_tag);
  assign rt_safe      = rt_live && rt_older_all && !flush;
  assign retire_now   = rt_commit && rt_safe;
  assign rt_fault     = retire_now && ent_fault[rt_idx];

  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> (ent_valid == {DEPTH{1'b1}})); // R4
  AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_grant |-> !ent_valid[ld_idx]); // R1
  AST_GRANT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_grant |=> ent_valid[$past(ld_idx)]); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_valid == '0)); // R9
  AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec)); // R8
  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_now && !ld_grant) |=> !ent_valid[$past(rt_idx)]); // R6
  AST_FAULT_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    rt_fault |-> (rt_commit && rt_live)); // R6
  AST_UNSAFE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_commit && rt_live && !rt_older_all && !flush && !ent_hit[rt_idx]) |=> ent_valid[$past(rt_idx)]); // R11
endmodule

// File: tb/spec_load_table_test.sv
module spec_load_table_test;
  localparam int D  = 8;
  localparam int WQ = 4;
  localparam int AW = 32;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic ld_valid = 1'b0, ld_spec = 1'b0, ld_fault = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [TW-1:0] ld_tag = '0;
  logic ld_grant, ld_stall, ld_raw;
  logic [2:0] ld_idx;
  logic [WQ-1:0] wbq_vld = '0;
  logic [AW-1:0] wq_a [WQ];
  logic [WQ*AW-1:0] wbq_addr;
  logic st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [TW-1:0] st_tag = '0;
  logic [D-1:0] sq_vec;
  logic [D*TW-1:0] sq_tags;
  logic pend_any = 1'b0;
  logic [TW-1:0] pend_tag = '0;
  logic [2:0] rt_idx = '0;
  logic rt_commit = 1'b0;
  logic rt_safe, rt_fault;

  for (genvar k = 0; k < WQ; k++) begin : g_wq
    assign wbq_addr[k*AW +: AW] = wq_a[k];
  end

  always #10 clk = ~clk;

  spec_load_table uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ld_valid(ld_valid), .ld_spec(ld_spec), .ld_addr(ld_addr), .ld_tag(ld_tag),
    .ld_fault(ld_fault), .ld_grant(ld_grant), .ld_idx(ld_idx), .ld_stall(ld_stall),
    .ld_raw(ld_raw), .wbq_vld(wbq_vld), .wbq_addr(wbq_addr),
    .st_valid(st_valid), .st_addr(st_addr), .st_tag(st_tag),
    .sq_vec(sq_vec), .sq_tags(sq_tags), .pend_any(pend_any), .pend_tag(pend_tag),
    .rt_idx(rt_idx), .rt_commit(rt_commit), .rt_safe(rt_safe), .rt_fault(rt_fault)
  );

  // reference model state
  bit          m_v [D];
  int unsigned m_a [D];
  int unsigned m_t [D];
  bit          m_f [D];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic bit older(int unsigned a, int unsigned b);
    return ((a - b) & 63) >= 32;
  endfunction

  function automatic bit same_word(int unsigned a, int unsigned b);
    return (a >> 2) == (b >> 2);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    flush = 0; ld_valid = 0; ld_spec = 0; ld_fault = 0;
    st_valid = 0; rt_commit = 0; wbq_vld = '0;
  endtask

  // compare every output against the model, then advance the model one clock
  task automatic step(input string req);
    bit e_raw, e_grant, e_stall, e_safe, e_rtf, full, found;
    int e_idx;
    bit [D-1:0] e_sq;
    logic [D*TW-1:0] e_tags;
    full = 1; found = 0; e_idx = 0;
    for (int i = D - 1; i >= 0; i--) if (!m_v[i]) begin found = 1; e_idx = i; end
    for (int i = 0; i < D; i++) if (!m_v[i]) full = 0;
    e_raw = 0;
    for (int k = 0; k < WQ; k++) if (wbq_vld[k] && same_word(wq_a[k], ld_addr)) e_raw = 1;
    if (st_valid && same_word(st_addr, ld_addr) && older(st_tag, ld_tag)) e_raw = 1;
    e_raw   = e_raw && ld_valid;
    e_grant = ld_valid && ld_spec && found && !flush && !e_raw;
    e_stall = ld_valid && ld_spec && full && !flush;
    e_tags  = '0;
    for (int i = 0; i < D; i++) begin
      e_sq[i] = !flush && st_valid && m_v[i] && same_word(m_a[i], st_addr) && older(st_tag, m_t[i]);
      if (e_sq[i]) e_tags[i*TW +: TW] = TW'(m_t[i]);
    end
    e_safe = !flush && m_v[rt_idx] && (!pend_any || older(m_t[rt_idx], pend_tag));
    e_rtf  = rt_commit && e_safe && m_f[rt_idx];
    #2;
    chk({req, " R5"}, "ld_raw", ld_raw, e_raw);
    chk({req, " R1"}, "ld_grant", ld_grant, e_grant);
    if (e_grant) chk({req, " R8"}, "ld_idx", ld_idx, e_idx);
    chk({req, " R4"}, "ld_stall", ld_stall, e_stall);
    chk({req, " R2"}, "sq_vec", sq_vec, e_sq);
    chk({req, " R10"}, "sq_tags", sq_tags, e_tags);
    chk({req, " R6"}, "rt_safe", rt_safe, e_safe);
    chk({req, " R6"}, "rt_fault", rt_fault, e_rtf);
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < D; i++) m_v[i] = 0;
    end else begin
      for (int i = 0; i < D; i++) if (e_sq[i]) m_v[i] = 0;
      if (rt_commit && e_safe) m_v[rt_idx] = 0;
      if (e_grant) begin
        m_v[e_idx] = 1; m_a[e_idx] = ld_addr; m_t[e_idx] = ld_tag; m_f[e_idx] = ld_fault;
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic spec_load(input int unsigned a, input int unsigned t, input bit f, input string req);
    ld_valid = 1; ld_spec = 1; ld_addr = a; ld_tag = TW'(t); ld_fault = f;
    step(req);
  endtask

  task automatic store(input int unsigned a, input int unsigned t, input string req);
    st_valid = 1; st_addr = a; st_tag = TW'(t);
    step(req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < WQ; k++) wq_a[k] = '0;
    for (int i = 0; i < D; i++) begin m_v[i] = 0; m_a[i] = 0; m_t[i] = 0; m_f[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // reset state: nothing live, nothing safe
    rt_idx = 0;
    step("R1 reset");
    chk("R1 reset", "rt_safe", rt_safe, 0);

    // fill the table, lowest slot first (R8), slot 0 carries a fault
    pend_any = 1; pend_tag = 5;
    for (int i = 0; i < D; i++) begin
      int unsigned a;
      a = 'h100 + 16 * i;
      if (i == 1) a = 'h131;
      if (i == 3) a = 'h132;
      spec_load(a, 10 + i, i == 0, "R8 fill");
    end
    // full: R4 stall
    spec_load('h700, 30, 0, "R4 full");
    // R11: unsafe retire on slot 2 is ignored
    rt_idx = 2; rt_commit = 1; step("R11 unsafe commit");
    rt_idx = 2; step("R11 still live");
    // R7 + R10: two byte addresses in word 0x130 squashed by one older store
    store('h130, 5, "R7 R10 multi");
    // freed slots reused lowest first
    spec_load('h200, 20, 0, "R8 reuse");
    spec_load('h204, 21, 0, "R8 reuse2");
    // R3: store younger than slot 5 (tag 15) does not squash it
    store('h150, 16, "R3 younger store");
    store('h150, 15, "R3 equal tag");
    store('h153, 14, "R3 older store");
    // R6: retire slot 0 once every older store has committed, fault shown then
    pend_tag = 11; rt_idx = 0; step("R6 query");
    rt_idx = 0; rt_commit = 1; step("R6 retire");
    pend_any = 0; rt_idx = 2; step("R11 slot kept");
    rt_idx = 2; rt_commit = 1; step("R6 retire2");
    // R5: write-back queue hazard for plain and speculative loads
    wq_a[2] = 'h300; wbq_vld = 4'b0100;
    ld_valid = 1; ld_addr = 'h303; ld_tag = 33; step("R5 wbq plain");
    wq_a[2] = 'h300; wbq_vld = 4'b0100;
    ld_valid = 1; ld_spec = 1; ld_addr = 'h302; ld_tag = 34; step("R5 wbq spec");
    wq_a[1] = 'h300; wbq_vld = 4'b0001;
    ld_valid = 1; ld_spec = 1; ld_addr = 'h302; ld_tag = 35; step("R5 wbq other slot");
    // same-cycle allocation and store commit
    ld_valid = 1; ld_spec = 1; ld_addr = 'h400; ld_tag = 40;
    st_valid = 1; st_addr = 'h401; st_tag = 39; step("R5 concurrent older store");
    ld_valid = 1; ld_spec = 1; ld_addr = 'h400; ld_tag = 40;
    st_valid = 1; st_addr = 'h401; st_tag = 41; step("R5 concurrent younger store");
    // R9: flush overrides allocation, squash and retire
    pend_any = 0; rt_idx = 1;
    ld_valid = 1; ld_spec = 1; ld_addr = 'h600; ld_tag = 42;
    st_valid = 1; st_addr = 'h200; st_tag = 3; rt_commit = 1; flush = 1;
    step("R9 flush");
    for (int i = 0; i < D; i++) begin
      rt_idx = 3'(i); step("R9 empty");
      chk("R9 empty", "rt_safe", rt_safe, 0);
    end
    // R3 wrap: tag 62 is older than 63, tag 1 is younger
    pend_any = 1; pend_tag = 60;
    spec_load('h500, 62, 0, "R3 wrap a");
    spec_load('h502, 1, 1, "R3 wrap b");
    store('h501, 63, "R3 wrap store");
    rt_idx = 1; step("R3 wrap gone");
    chk("R3 wrap", "rt_safe slot1", rt_safe, 0);
    pend_any = 0; rt_idx = 0; rt_commit = 1; step("R6 wrap retire");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule